// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Mapper

This block sits between a CPU's 16-bit address bus and a cartridge's ROM and battery-free SRAM. It watches CPU writes aimed at the ROM area, 0x0000–0x7FFF, and treats them as control writes, because ROM cannot be written. From those writes it keeps four pieces of state: an SRAM access gate, a 9-bit ROM bank number, a RAM bank field and a rumble motor bit.

On the read side it forms the wide ROM address from the CPU address. The lower 16 KB window, 0x0000–0x3FFF, always shows bank 0. The upper 16 KB window, 0x4000–0x7FFF, shows the selected bank. For the 8 KB window at 0xA000–0xBFFF it forms the SRAM address and the SRAM chip enable. When SRAM access is shut, it raises a fill output instead, which tells the bus to return 0xFF.

The ROM bank number is loaded through two registers. One holds the low byte and the other holds bit 8. When the rumble variant is built, the top bit of the RAM bank field drives the motor and does not address memory. Register writes take effect at the clock edge on which the write strobe is sampled high. All address outputs are combinational from the current address and the registered state.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, SRAM access is shut, the ROM bank is 1, the RAM bank field is 0 and `rumble` is low.
- R2: A write anywhere in 0x0000–0x1FFF opens SRAM access when the data byte is exactly 0x0A. Any other byte shuts SRAM access.
- R3: A write in 0x2000–0x2FFF loads ROM bank bits 7..0 from the data byte and leaves bit 8 unchanged.
- R4: A write in 0x3000–0x3FFF loads ROM bank bit 8 from data bit 0 and ignores the other data bits. For CPU addresses 0x4000–0x7FFF, `romAddr` is {bank[8:0], cpuAddr[13:0]}.
- R5: For CPU addresses 0x0000–0x3FFF, `romAddr` is {9'b0, cpuAddr[13:0]}, whatever bank is selected.
- R6: A ROM bank value of 0 maps bank 0 into the upper window. It is not replaced by bank 1.
- R7: A write in 0x4000–0x5FFF loads the 4-bit RAM bank field from data bits 3..0. `sramAddr` is {bank, cpuAddr[12:0]}. In the rumble variant (the default), the bank bit 3 in `sramAddr` is 0.
- R8: In the rumble variant, `rumble` equals bit 3 of the last RAM bank write.
- R9: `sramCe` is high only while SRAM access is open, the CPU address is in 0xA000–0xBFFF, and `cpuRd` or `cpuWr` is high.
- R10: While SRAM access is shut, a read in 0xA000–0xBFFF raises `sramFill` and keeps `sramCe` low. A write there raises neither signal.
- R11: Writes in 0x6000–0x7FFF or at 0x8000 and above change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| cpuWr | input | 1 | CPU write strobe, sampled at each rising edge |
| cpuRd | input | 1 | CPU read strobe |
| romAddr | output | 23 | Banked ROM address |
| sramAddr | output | 17 | Banked SRAM address |
| sramCe | output | 1 | SRAM chip enable |
| sramFill | output | 1 | Drive 0xFF onto the bus for a read while SRAM is shut |
| rumble | output | 1 | Rumble motor drive |

## Verification
Every piece of state in this block shows up directly on an output in the cycle after the write that changed it:
- A wrong ROM bank register appears in the upper bits of `romAddr` on the next read of 0x4000–0x7FFF.
- A wrong RAM bank field appears in `sramAddr` and `rumble` straight away.
- A wrong access gate flips `sramCe` and `sramFill` on the next access to the SRAM window.

The bench therefore follows each control write with probes of the affected window. It checks that writes to the ignored ranges leave all of these outputs unchanged.

// File: rtl/cbm_pkg.sv
`timescale 1ns/1ps
package cbm_pkg;
  // Register write strobes from address decode; at most one is high per cycle.
  typedef struct packed {
    logic gateWr;     // 0x0000-0x1FFF
    logic romLoWr;    // 0x2000-0x2FFF
    logic romHiWr;    // 0x3000-0x3FFF
    logic ramBankWr;  // 0x4000-0x5FFF
  } cbmStrobe_t;
endpackage

// File: rtl/cbm_ctrl.sv
`timescale 1ns/1ps
module cbm_ctrl
  import cbm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] addrTop,   // cpuAddr[15:12]
  input  logic       cpuWr,
  output cbmStrobe_t strobe,
  output logic       inLowRom,
  output logic       inSramWin
);

  always_comb begin
    strobe           = '0;
    strobe.gateWr    = cpuWr && (addrTop[3:1] == 3'b000);
    strobe.romLoWr   = cpuWr && (addrTop == 4'b0010);
    strobe.romHiWr   = cpuWr && (addrTop == 4'b0011);
    strobe.ramBankWr = cpuWr && (addrTop[3:1] == 3'b010);
  end

  assign inLowRom  = (addrTop[3:2] == 2'b00);
  assign inSramWin = (addrTop[3:1] == 3'b101);

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)); // R11

  AST_HIGH_WR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (addrTop[3] || addrTop[2:1] == 2'b11) |-> (strobe == '0)); // R11

endmodule

// File: rtl/cbm_regs.sv
`timescale 1ns/1ps
module cbm_regs
  import cbm_pkg::*;
#(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4,
  parameter int ROM_OFS_W  = 14,
  parameter int RAM_OFS_W  = 13,
  parameter int DATA_W     = 8,
  parameter bit HAS_RUMBLE = 1'b1,
  parameter logic [DATA_W-1:0] OPEN_KEY = 8'h0A
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  cbmStrobe_t                    strobe,
  input  logic [DATA_W-1:0]             cpuData,
  input  logic [ROM_OFS_W-1:0]          addrOfs,
  input  logic                          inLowRom,
  input  logic                          inSramWin,
  input  logic                          cpuRd,
  input  logic                          cpuWr,
  output logic [ROM_BANK_W+ROM_OFS_W-1:0] romAddr,
  output logic [RAM_BANK_W+RAM_OFS_W-1:0] sramAddr,
  output logic                          sramCe,
  output logic                          sramFill,
  output logic                          rumble
);

  localparam int LO_W = ROM_BANK_W - 1;

  logic                  ramOn;
  logic [ROM_BANK_W-1:0] romBank;
  logic [RAM_BANK_W-1:0] ramSel;
  logic [RAM_BANK_W-1:0] effBank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramOn   <= 1'b0;
      romBank <= ROM_BANK_W'(1);
      ramSel  <= '0;
    end else begin
      if (strobe.gateWr)    ramOn <= (cpuData == OPEN_KEY);
      if (strobe.romLoWr)   romBank[LO_W-1:0] <= cpuData[LO_W-1:0];
      if (strobe.romHiWr)   romBank[LO_W] <= cpuData[0];
      if (strobe.ramBankWr) ramSel <= cpuData[RAM_BANK_W-1:0];
    end
  end

  generate
    if (HAS_RUMBLE) begin : g_rumble
      assign effBank = {1'b0, ramSel[RAM_BANK_W-2:0]};
      assign rumble  = ramSel[RAM_BANK_W-1];

      AST_RUMBLE_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
        strobe.ramBankWr |=> (rumble == $past(cpuData[RAM_BANK_W-1]))); // R8
    end else begin : g_plain
      assign effBank = ramSel;
      assign rumble  = 1'b0;
    end
  endgenerate

  assign romAddr  = inLowRom ? {ROM_BANK_W'(0), addrOfs}
                             : {romBank, addrOfs};
  assign sramAddr = {effBank, addrOfs[RAM_OFS_W-1:0]};
  assign sramCe   = ramOn && inSramWin && (cpuRd || cpuWr);
  assign sramFill = !ramOn && inSramWin && cpuRd;

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.gateWr |=> $stable(ramOn)); // R2

  AST_ROM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.romLoWr || strobe.romHiWr) |=> $stable(romBank)); // R3

  AST_RAMSEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ramBankWr |=> $stable(ramSel)); // R7

  AST_CE_FILL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(sramCe && sramFill)); // R10

endmodule

// File: rtl/cart_bank_mapper.sv
`timescale 1ns/1ps
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4,
  parameter int DATA_W     = 8,
  parameter bit HAS_RUMBLE = 1'b1,
  localparam int ADDR_W    = 16,
  localparam int ROM_OFS_W = 14,
  localparam int RAM_OFS_W = 13
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [ADDR_W-1:0]               cpuAddr,
  input  logic [DATA_W-1:0]               cpuData,
  input  logic                            cpuWr,
  input  logic                            cpuRd,
  output logic [ROM_BANK_W+ROM_OFS_W-1:0] romAddr,
  output logic [RAM_BANK_W+RAM_OFS_W-1:0] sramAddr,
  output logic                            sramCe,
  output logic                            sramFill,
  output logic                            rumble
);

  cbmStrobe_t strobe;
  logic       inLowRom;
  logic       inSramWin;

  cbm_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .addrTop  (cpuAddr[ADDR_W-1:ADDR_W-4]),
    .cpuWr    (cpuWr),
    .strobe   (strobe),
    .inLowRom (inLowRom),
    .inSramWin(inSramWin)
  );

  cbm_regs #(
    .ROM_BANK_W(ROM_BANK_W),
    .RAM_BANK_W(RAM_BANK_W),
    .ROM_OFS_W (ROM_OFS_W),
    .RAM_OFS_W (RAM_OFS_W),
    .DATA_W    (DATA_W),
    .HAS_RUMBLE(HAS_RUMBLE)
  ) i_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cpuData  (cpuData),
    .addrOfs  (cpuAddr[ROM_OFS_W-1:0]),
    .inLowRom (inLowRom),
    .inSramWin(inSramWin),
    .cpuRd    (cpuRd),
    .cpuWr    (cpuWr),
    .romAddr  (romAddr),
    .sramAddr (sramAddr),
    .sramCe   (sramCe),
    .sramFill (sramFill),
    .rumble   (rumble)
  );

endmodule

// File: tb/test_cart_bank_mapper.sv
`timescale 1ns/1ps
module test_cart_bank_mapper;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic        cpuWr = 1'b0;
  logic        cpuRd = 1'b0;
  logic [22:0] romAddr;
  logic [16:0] sramAddr;
  logic        sramCe, sramFill, rumble;

  always #4 clk = ~clk;  // 125 MHz

  cart_bank_mapper i_cart_bank_mapper (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .romAddr(romAddr), .sramAddr(sramAddr),
    .sramCe(sramCe), .sramFill(sramFill), .rumble(rumble)
  );

  typedef logic [42:0] item_t;  // {romAddr, sramAddr, sramCe, sramFill, rumble}
  item_t expQ[$];
  string tagQ[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  // Reference state derived from the requirements
  logic       mOpen;
  logic [8:0] mRom;
  logic [3:0] mRam;

  task automatic modelReset();
    mOpen = 1'b0; mRom = 9'd1; mRam = 4'd0;  // R1
  endtask

  function automatic item_t expect_at(logic [15:0] a, logic rd, logic wr);
    logic [22:0] r;
    logic        win;
    r   = (a < 16'h4000) ? {9'd0, a[13:0]} : {mRom, a[13:0]};
    win = (a[15:13] == 3'b101);
    return {r, {1'b0, mRam[2:0], a[12:0]}, mOpen & win & (rd | wr),
            ~mOpen & win & rd, mRam[3]};
  endfunction

  task automatic probe(logic [15:0] a, logic rd, logic wr, string tag);
    @(negedge clk);
    cpuAddr = a; cpuRd = rd; cpuWr = wr; cpuData = 8'h5A;
    expQ.push_back(expect_at(a, rd, wr));
    tagQ.push_back(tag);
    @(posedge clk);
  endtask

  task automatic writeReg(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuData = d; cpuWr = 1'b1; cpuRd = 1'b0;
    @(posedge clk);
    if (a < 16'h2000)      mOpen = (d == 8'h0A);
    else if (a < 16'h3000) mRom[7:0] = d;
    else if (a < 16'h4000) mRom[8] = d[0];
    else if (a < 16'h6000) mRam = d[3:0];
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cpuWr = 1'b0; cpuRd = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  // Monitor: compare between edges
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (expQ.size() > 0) begin
        item_t e, act;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        act = {romAddr, sramAddr, sramCe, sramFill, rumble};
        checks++;
        if (act !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, act, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    probe(16'h4000, 1, 0, "R1 reset rom bank");
    probe(16'hA000, 1, 0, "R1 R10 reset sram shut");
    probe(16'h2345, 1, 0, "R5 low window");
    writeReg(16'h2000, 8'h05);
    probe(16'h4123, 1, 0, "R3 low byte");
    writeReg(16'h3000, 8'hFF);
    probe(16'h7FFF, 1, 0, "R4 bit8");
    writeReg(16'h2FFF, 8'h00);
    probe(16'h6000, 1, 0, "R3 bit8 kept");
    writeReg(16'h3FFF, 8'hFE);
    probe(16'h5000, 1, 0, "R6 bank zero");
    writeReg(16'h2ABC, 8'hAB);
    writeReg(16'h3001, 8'h01);
    probe(16'h0010, 1, 0, "R5 low window fixed");
    probe(16'h4001, 1, 0, "R4 bank 1AB");
    writeReg(16'h1FFF, 8'h0A);
    probe(16'hB000, 1, 0, "R2 R9 open read");
    probe(16'hA001, 0, 1, "R9 open write");
    probe(16'hA002, 0, 0, "R9 idle");
    probe(16'hC000, 1, 0, "R9 outside window");
    writeReg(16'h4000, 8'h07);
    probe(16'hA123, 1, 0, "R7 ram bank 7");
    writeReg(16'h5FFF, 8'h0D);
    probe(16'hBFFF, 1, 0, "R7 R8 rumble on");
    writeReg(16'h4444, 8'hF2);
    probe(16'hA800, 1, 0, "R8 rumble off");
    writeReg(16'h0000, 8'h0B);
    probe(16'hA010, 1, 0, "R2 R10 shut read");
    probe(16'hA010, 0, 1, "R10 shut write");
    writeReg(16'h0800, 8'h0A);
    writeReg(16'h1000, 8'h00);
    probe(16'hB100, 1, 0, "R2 zero shuts");
    writeReg(16'h1234, 8'h0A);
    writeReg(16'h6000, 8'h00);
    writeReg(16'h7FFF, 8'hFF);
    writeReg(16'h8000, 8'h00);
    writeReg(16'hA000, 8'h0B);
    writeReg(16'hFFFF, 8'h00);
    probe(16'h4321, 1, 0, "R11 rom bank kept");
    probe(16'hA321, 1, 0, "R11 gate and ram bank kept");
    doReset();
    probe(16'h7000, 1, 0, "R1 after reset rom");
    probe(16'hA000, 1, 0, "R1 after reset sram");
    @(negedge clk);
    #3;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule